// File: doc/BRIEF.md
# Seeded 8-bit Pseudo-Random Byte Generator

This block produces a new pseudo-random byte on every enabled clock from a linear-feedback shift register. The state register and the output byte are the same thing, so the byte seen on the output is the full internal state. Given the same starting state, the sequence repeats exactly, and with the default primitive feedback taps the state visits all 255 non-zero values before it repeats.

There are three ways to put a starting state into the register. A static mode input picks one of two reset behaviours. The first is a parallel preset that loads all ones on reset. The second clears the register on reset and then shifts in a constant one on each of the following clock cycles until the register is full of ones. A ready flag is low while that fill runs. At any time after the fill, a serial load input can shift an arbitrary seed into the register, one bit per cycle. During that load the feedback path is bypassed.

Top module: `prng8_multi_init`

## Requirements
- R1: The sequence is deterministic. After a serial fill of ones, stepping gives exactly the same bytes as stepping after a parallel preset.
- R2: With `fill_mode`=0, a cycle with `rst`=1 leaves `rnd_out`=8'hFF and `ready`=1 after that clock edge.
- R3: With `fill_mode`=1, a cycle with `rst`=1 leaves `rnd_out`=8'h00 and `ready`=0. On each of the next 8 edges, `rnd_out` becomes {rnd_out[6:0],1'b1}, whatever `en`, `seed_load` and `seed_bit` are.
- R4: `ready` is 0 while the fill runs. It becomes 1 on the 8th edge after reset and stays 1 until the next reset.
- R5: When `ready`=1, `en`=1 and `seed_load`=0, each edge sets `rnd_out` to {rnd_out[6:0], rnd_out[7]^rnd_out[5]^rnd_out[4]^rnd_out[3]}. Starting from FF, the outputs are FE, FC, F8, F0, E1, C2, 85, 0B.
- R6: Stepping from any non-zero state returns to that state after exactly 255 steps and not earlier.
- R7: When `ready`=1, `en`=0 and `seed_load`=0, `rnd_out` holds its value.
- R8: When `ready`=1 and `seed_load`=1, each edge sets `rnd_out` to {rnd_out[6:0], seed_bit}, so a seed is loaded MSB first in 8 cycles. This load takes priority over `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fill_mode | input | 1 | Static: 0 = parallel preset to ones, 1 = serial fill of ones after reset |
| en | input | 1 | Step the generator one position |
| seed_load | input | 1 | Shift `seed_bit` into the state instead of feedback |
| seed_bit | input | 1 | Serial seed data, MSB first |
| rnd_out | output | 8 | Current state / pseudo-random byte |
| ready | output | 1 | High once the state is initialised |

## Verification
The seed load and the normal step can both be requested in the same cycle. The bench drives `seed_load` and `en` high together for a whole seed. It expects the shifted-in seed bits and none of the feedback, and it then checks that the next plain step continues the recurrence from the loaded byte. A second collision is also tested: the serial fill runs with `en` and `seed_load` high and `seed_bit`=0. The expected outputs are 01, 03, … FF, which show that only constant ones entered the register.

// File: rtl/prng_pkg.sv
package prng_pkg;

    // Per-cycle update applied to the state register
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_FILL = 2'd1,
        ACT_SEED = 2'd2,
        ACT_STEP = 2'd3
    } prng_act_e;

    // Default taps for an 8-bit maximal sequence: bits 7,5,4,3
    localparam logic [7:0] PRNG_TAPS_DEFAULT = 8'hB8;

    // Feedback bit: parity of the tapped state bits
    function automatic logic fb_parity(input logic [63:0] state, input logic [63:0] taps);
        return ^(state & taps);
    endfunction

endpackage

// File: rtl/prng_fill_ctrl.sv
module prng_fill_ctrl #(
    parameter int STATE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fill_mode,
    output logic filling,
    output logic ready
);
    localparam int CNT_W = $clog2(STATE_W + 1);

    logic [CNT_W-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= fill_mode ? CNT_W'(STATE_W) : '0;
        end else if (fill_cnt != '0) begin
            fill_cnt <= fill_cnt - 1'b1;
        end
    end

    assign filling = (fill_cnt != '0);
    assign ready   = ~filling;

    // R4: once ready, stays ready until reset
    a_r4_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R4: the fill never lasts longer than the state width
    logic [CNT_W:0] fill_len;
    always_ff @(posedge clk) begin
        if (rst)          fill_len <= '0;
        else if (filling) fill_len <= fill_len + 1'b1;
    end
    a_r4_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        fill_len <= (CNT_W+1)'(STATE_W));

endmodule

// File: rtl/prng_act_sel.sv
module prng_act_sel
    import prng_pkg::*;
(
    input  logic      filling,
    input  logic      en,
    input  logic      seed_load,
    output prng_act_e act
);
    // Priority: fill, then seed load, then step
    always_comb begin
        if (filling)        act = ACT_FILL;
        else if (seed_load) act = ACT_SEED;
        else if (en)        act = ACT_STEP;
        else                act = ACT_HOLD;
    end

    a_r8_seed_over_step: assert final (!(seed_load && !filling) || act == ACT_SEED);

endmodule

// File: rtl/prng_shift_state.sv
module prng_shift_state
    import prng_pkg::*;
#(
    parameter int                 STATE_W = 8,
    parameter logic [STATE_W-1:0] TAPS    = STATE_W'(PRNG_TAPS_DEFAULT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               preset_ones,
    input  prng_act_e          act,
    input  logic               seed_bit,
    output logic [STATE_W-1:0] q
);
    logic fb;
    assign fb = fb_parity(64'(q), 64'(TAPS));

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= preset_ones ? '1 : '0;
        end else begin
            unique case (act)
                ACT_FILL: q <= {q[STATE_W-2:0], 1'b1};
                ACT_SEED: q <= {q[STATE_W-2:0], seed_bit};
                ACT_STEP: q <= {q[STATE_W-2:0], fb};
                default:  q <= q;
            endcase
        end
    end

    // R3: fill shifts a one into the low end
    a_r3_fill_shift: assert property (@(posedge clk) disable iff (rst)
        act == ACT_FILL |=> q == {$past(q[STATE_W-2:0]), 1'b1});

    // R8: seed load bypasses feedback
    a_r8_seed_shift: assert property (@(posedge clk) disable iff (rst)
        act == ACT_SEED |=> q == {$past(q[STATE_W-2:0]), $past(seed_bit)});

    // R7: hold keeps the state
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        act == ACT_HOLD |=> $stable(q));

endmodule

// File: rtl/prng8_multi_init.sv
module prng8_multi_init
    import prng_pkg::*;
#(
    parameter int                 STATE_W = 8,
    parameter logic [STATE_W-1:0] TAPS    = STATE_W'(PRNG_TAPS_DEFAULT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill_mode,
    input  logic               en,
    input  logic               seed_load,
    input  logic               seed_bit,
    output logic [STATE_W-1:0] rnd_out,
    output logic               ready
);
    logic      filling;
    prng_act_e act;

    prng_fill_ctrl #(.STATE_W(STATE_W)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .fill_mode (fill_mode),
        .filling   (filling),
        .ready     (ready)
    );

    prng_act_sel u_sel (
        .filling   (filling),
        .en        (en),
        .seed_load (seed_load),
        .act       (act)
    );

    prng_shift_state #(.STATE_W(STATE_W), .TAPS(TAPS)) u_state (
        .clk         (clk),
        .rst         (rst),
        .preset_ones (~fill_mode),
        .act         (act),
        .seed_bit    (seed_bit),
        .q           (rnd_out)
    );

    // R2: parallel preset loads all ones and is ready at once
    a_r2_preset: assert property (@(posedge clk)
        (rst && !fill_mode) |=> (rnd_out == '1) && ready);

    // R3: serial-fill reset clears the state and drops ready
    a_r3_fill_clear: assert property (@(posedge clk)
        (rst && fill_mode) |=> (rnd_out == '0) && !ready);

    // R5: a non-zero state never steps to zero
    a_r5_no_lockup: assert property (@(posedge clk) disable iff (rst)
        (ready && en && !seed_load && rnd_out != '0) |=> rnd_out != '0);

endmodule

// File: tb/prng8_multi_init_tb.sv
module prng8_multi_init_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fill_mode = 1'b0;
    logic       en = 1'b0;
    logic       seed_load = 1'b0;
    logic       seed_bit = 1'b0;
    logic [7:0] rnd_out;
    logic       ready;

    always #5 clk = ~clk;

    prng8_multi_init dut_i (
        .clk       (clk),
        .rst       (rst),
        .fill_mode (fill_mode),
        .en        (en),
        .seed_load (seed_load),
        .seed_bit  (seed_bit),
        .rnd_out   (rnd_out),
        .ready     (ready)
    );

    typedef struct {
        int         due;
        logic [7:0] exp_out;
        logic       exp_rdy;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int cycle_no = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cycle_no <= cycle_no + 1;

    // Monitor: compare expected items as their cycle comes due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cycle_no) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (rnd_out !== it.exp_out || ready !== it.exp_rdy) begin
                n_bad++;
                $display("FAIL %s: out=%h ready=%b expected out=%h ready=%b",
                         it.tag, rnd_out, ready, it.exp_out, it.exp_rdy);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue what must follow
    task automatic drive(input logic r, input logic e, input logic sl, input logic sb,
                         input logic fm, input logic [7:0] x_out, input logic x_rdy,
                         input string tag);
        rst = r; en = e; seed_load = sl; seed_bit = sb; fill_mode = fm;
        sb_q.push_back('{cycle_no + 1, x_out, x_rdy, tag});
        @(negedge clk);
    endtask

    task automatic direct_check(input bit ok, input string tag,
                                input int act_v, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // Recurrence taken from R5
    function automatic logic [7:0] model_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    logic [7:0] known [8] = '{8'hFE, 8'hFC, 8'hF8, 8'hF0, 8'hE1, 8'hC2, 8'h85, 8'h0B};

    initial begin
        logic [7:0] m;
        logic [7:0] start;
        int early;
        @(negedge clk);

        // R2: parallel preset
        drive(1, 0, 0, 0, 0, 8'hFF, 1, "R2");
        drive(1, 0, 0, 0, 0, 8'hFF, 1, "R2");

        // R5: first steps from all ones
        for (int i = 0; i < 8; i++) drive(0, 1, 0, 0, 0, known[i], 1, "R5");
        m = 8'h0B;

        // R7: hold with enable low, seed_bit wiggling
        for (int i = 0; i < 3; i++) drive(0, 0, 0, i[0], 0, m, 1, "R7");

        // R6: full period
        start = m;
        early = 0;
        for (int i = 1; i <= 255; i++) begin
            m = model_next(m);
            drive(0, 1, 0, 0, 0, m, 1, "R6");
            if (i < 255 && rnd_out == start) early++;
        end
        direct_check(early == 0, "R6 early return", early, 0);
        direct_check(rnd_out == start, "R6 period", rnd_out, start);

        // R8: seed A5 loaded MSB first while en is also high
        for (int i = 7; i >= 0; i--) begin
            logic b;
            b = 8'hA5 >> i;
            m = {m[6:0], b};
            drive(0, 1, 1, b, 0, m, 1, "R8");
        end
        direct_check(rnd_out == 8'hA5, "R8 seed value", rnd_out, 8'hA5);
        m = model_next(m);
        drive(0, 1, 0, 0, 0, m, 1, "R5 after seed");

        // R3/R4: serial fill, en and seed_load asserted but ignored
        drive(1, 0, 0, 0, 1, 8'h00, 0, "R3 reset");
        drive(1, 0, 0, 0, 1, 8'h00, 0, "R3 reset");
        for (int k = 1; k <= 8; k++)
            drive(0, 1, 1, 0, 1, 8'((16'd1 << k) - 1), (k == 8), "R3 R4 fill");

        // R1: same sequence as after parallel preset; R4 ready stays high
        for (int i = 0; i < 8; i++) drive(0, 1, 0, 0, 1, known[i], 1, "R1 R4");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule